// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a pipelined arithmetic slice. It adds or subtracts two operands, multiplies the result by a third operand, and then combines that product with other values in a final adder. A typical use is to form `(D - A) * B` in a filter tap. The same final adder can also pass through a wide operand, accumulate onto its own previous output, or subtract. Three mode words choose the function. The operation word picks the three operands of the final adder. The ALU word picks add or subtract. The input word picks the sign of the pre-adder and which B register feeds the multiplier.

Each pipeline register has its own clock enable and its own synchronous clear. This lets a host hold, flush or restart any stage without touching the others. With all enables high, an operand applied to A, D or B (through the second B register) reaches the output four clocks later. The control words are registered once. They act on the result register one clock after they are captured. The wide C operand is not registered and is sampled at the edge that loads the result.

Top module: `premac_slice`

## Requirements
- R1: An asynchronous active-low reset clears every register, so `p_out` reads zero while the reset is low, including when it is asserted in the middle of a run.
- R2: When `inmode_in[3]`=1, `inmode_in[4]`=0, `opmode_in`=7'b0000101 and `alumode_in`=4'b0000, `p_out` equals `(D - A) * B`, four clocks after the operands are applied. A contributes its low 25 bits as a signed value. The difference is kept at 26 bits with no wrap. The signed product is sign-extended to 48 bits.
- R3: When `inmode_in[3]`=0, the pre-adder forms `D + A`. When `inmode_in[4]`=1, the multiplier takes the first-stage B register, so B reaches `p_out` in three clocks instead of four. The input-mode word is captured in its own register one clock before the pre-adder register and the multiplier register use it.
- R4: The post-adder operand selects are X=`opmode_in[1:0]`, Y=`opmode_in[3:2]` and Z=`opmode_in[6:4]`. Code 0 on each gives a zero operand. With all three zero and the carry clear, `p_out` is zero.
- R5: X code 01 passes bits [23:0] of the 48-bit product and zeroes the rest. Y code 01 passes bits [47:24] and zeroes the rest. With both at 01, the sum equals the product exactly once.
- R6: Z code 010 feeds `p_out` back into the post-adder, so the result accumulates. With X and Y zero and the carry clear, `p_out` holds its value.
- R7: Z code 011 and Y code 11 each select `c_in`, taken at the edge that loads `p_out`. X code 11 selects the first-stage A register concatenated above the first-stage B register (A in bits [47:18]).
- R8: `alumode_in`=4'b0011 makes the result Z - (X + Y + carry). Every other ALU-mode value gives Z + X + Y + carry.
- R9: `opmode_in`, `alumode_in` and `carry_in` are captured together in a control register. They act on `p_out` at the next clock edge after capture. A set carry adds one to the result.
- R10: A low clock enable holds the register it controls. For example, with `ce_a` low the old A value stays in use, and with `ce_p` low `p_out` does not change.
- R11: A synchronous clear sets its register to zero at the next edge and takes priority over that register's clock enable.
- R12: Bits [2:0] of `inmode_in` have no effect on `p_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 30 | Operand A; low 25 bits enter the pre-adder |
| b_in | input | 18 | Signed multiplier operand B |
| d_in | input | 25 | Signed pre-adder operand D |
| c_in | input | 48 | Wide post-adder operand C (unregistered) |
| opmode_in | input | 7 | X/Y/Z operand selects |
| alumode_in | input | 4 | Add (0000) or subtract (0011) |
| inmode_in | input | 5 | Bit 3 pre-adder sign, bit 4 B register select |
| carry_in | input | 1 | Post-adder carry |
| ce_a | input | 1 | Enable, A register |
| ce_b1 | input | 1 | Enable, first B register |
| ce_b2 | input | 1 | Enable, second B register |
| ce_d | input | 1 | Enable, D register |
| ce_ad | input | 1 | Enable, pre-adder register |
| ce_m | input | 1 | Enable, product register |
| ce_p | input | 1 | Enable, result register |
| ce_ctrl | input | 1 | Enable, control register |
| ce_inmode | input | 1 | Enable, input-mode register |
| rst_a | input | 1 | Synchronous clear, A register |
| rst_b | input | 1 | Synchronous clear, both B registers |
| rst_d | input | 1 | Synchronous clear, D register |
| rst_ad | input | 1 | Synchronous clear, pre-adder register |
| rst_m | input | 1 | Synchronous clear, product register |
| rst_p | input | 1 | Synchronous clear, result register |
| rst_ctrl | input | 1 | Synchronous clear, control register |
| rst_inmode | input | 1 | Synchronous clear, input-mode register |
| p_out | output | 48 | Result |

## Verification
The assertions check, on every cycle, the behaviours that depend only on the control path and the result register. These are: the zero result under all-zero selects, the held value during accumulation with zero addends, the pass-through of C, the hold when `ce_p` is low, the priority of the `p_out` clear over its enable, and the zero output during asynchronous reset. Arithmetic needs the bench's scenarios to show it. That covers the signed pre-adder in both signs, the product split across X and Y, the A:B concatenation, subtraction and carry, and the different latency of the two B registers. The per-stage enables and clears of A are also shown only by directed sequences, where their effect surfaces at `p_out` several clocks later.

// File: rtl/premac_pkg.sv
`timescale 1ns/1ps
package premac_pkg;
  // X select codes, opmode[1:0]
  localparam logic [1:0] XS_ZERO = 2'b00;
  localparam logic [1:0] XS_MLO  = 2'b01;
  localparam logic [1:0] XS_AB   = 2'b11;
  // Y select codes, opmode[3:2]
  localparam logic [1:0] YS_ZERO = 2'b00;
  localparam logic [1:0] YS_MHI  = 2'b01;
  localparam logic [1:0] YS_C    = 2'b11;
  // Z select codes, opmode[6:4]
  localparam logic [2:0] ZS_ZERO = 3'b000;
  localparam logic [2:0] ZS_P    = 3'b010;
  localparam logic [2:0] ZS_C    = 3'b011;
  // ALU modes
  localparam logic [3:0] ALU_ADD = 4'b0000;
  localparam logic [3:0] ALU_SUB = 4'b0011;
  // input-mode bit positions
  localparam int INM_SUB_BIT  = 3;
  localparam int INM_BSEL_BIT = 4;

  typedef struct packed {
    logic [6:0] opmode;
    logic [3:0] alumode;
    logic       carry;
  } ctrl_t;

  typedef struct packed {
    logic bsel_first;
    logic pre_sub;
  } inm_t;
endpackage

// File: rtl/premac_preadd.sv
`timescale 1ns/1ps
module premac_preadd #(
  parameter int A_W   = 30,
  parameter int D_W   = 25,
  parameter int PRE_W = D_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [A_W-1:0]          a_in,
  input  logic [D_W-1:0]          d_in,
  input  logic                    ce_a,
  input  logic                    ce_d,
  input  logic                    ce_ad,
  input  logic                    rst_a,
  input  logic                    rst_d,
  input  logic                    rst_ad,
  input  logic                    pre_sub,
  output logic [A_W-1:0]          a_q,
  output logic signed [PRE_W-1:0] ad_q
);
  localparam int EXT = PRE_W - D_W;

  logic [A_W-1:0]          a_nx;
  logic [D_W-1:0]          d_q, d_nx;
  logic signed [PRE_W-1:0] ad_nx, a_ext, d_ext;

  always_comb begin
    a_ext = {{EXT{a_q[D_W-1]}}, a_q[D_W-1:0]};
    d_ext = {{EXT{d_q[D_W-1]}}, d_q};
    a_nx  = rst_a ? '0 : (ce_a ? a_in : a_q);
    d_nx  = rst_d ? '0 : (ce_d ? d_in : d_q);
    if (rst_ad)      ad_nx = '0;
    else if (ce_ad)  ad_nx = pre_sub ? (d_ext - a_ext) : (d_ext + a_ext);
    else             ad_nx = ad_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      d_q  <= '0;
      ad_q <= '0;
    end else begin
      a_q  <= a_nx;
      d_q  <= d_nx;
      ad_q <= ad_nx;
    end
  end
endmodule

// File: rtl/premac_mult.sv
`timescale 1ns/1ps
module premac_mult #(
  parameter int B_W   = 18,
  parameter int PRE_W = 26,
  parameter int P_W   = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [B_W-1:0]          b_in,
  input  logic                    ce_b1,
  input  logic                    ce_b2,
  input  logic                    rst_b,
  input  logic                    ce_m,
  input  logic                    rst_m,
  input  logic                    bsel_first,
  input  logic signed [PRE_W-1:0] ad_q,
  output logic [B_W-1:0]          b1_q,
  output logic [P_W-1:0]          m_q
);
  localparam int PROD_W = PRE_W + B_W;

  logic [B_W-1:0]           b2_q, b1_nx, b2_nx;
  logic signed [B_W-1:0]    b_sel;
  logic signed [PROD_W-1:0] prod;
  logic [P_W-1:0]           m_nx;

  always_comb begin
    b1_nx = rst_b ? '0 : (ce_b1 ? b_in : b1_q);
    b2_nx = rst_b ? '0 : (ce_b2 ? b1_q : b2_q);
    b_sel = bsel_first ? b1_q : b2_q;
    prod  = PROD_W'(ad_q) * PROD_W'(b_sel);
    if (rst_m)     m_nx = '0;
    else if (ce_m) m_nx = {{(P_W-PROD_W){prod[PROD_W-1]}}, prod};
    else           m_nx = m_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1_q <= '0;
      b2_q <= '0;
      m_q  <= '0;
    end else begin
      b1_q <= b1_nx;
      b2_q <= b2_nx;
      m_q  <= m_nx;
    end
  end
endmodule

// File: rtl/premac_postadd.sv
`timescale 1ns/1ps
module premac_postadd
  import premac_pkg::*;
#(
  parameter int A_W = 30,
  parameter int B_W = 18,
  parameter int P_W = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [6:0]     opmode_in,
  input  logic [3:0]     alumode_in,
  input  logic           carry_in,
  input  logic           ce_ctrl,
  input  logic           rst_ctrl,
  input  logic [P_W-1:0] m_q,
  input  logic [A_W-1:0] a_q,
  input  logic [B_W-1:0] b_q,
  input  logic [P_W-1:0] c_in,
  input  logic           ce_p,
  input  logic           rst_p,
  output logic [P_W-1:0] p_q
);
  localparam int HALF = P_W / 2;
  localparam logic [P_W-1:0] LO_MASK = {{(P_W-HALF){1'b0}}, {HALF{1'b1}}};

  ctrl_t          ctrl_q, ctrl_nx, ctrl_in;
  logic [P_W-1:0] x_op, y_op, z_op, addend, p_calc, p_nx, ab_cat;

  always_comb begin
    ctrl_in = '{opmode: opmode_in, alumode: alumode_in, carry: carry_in};
    ctrl_nx = rst_ctrl ? '0 : (ce_ctrl ? ctrl_in : ctrl_q);
    ab_cat  = P_W'({a_q, b_q});

    case (ctrl_q.opmode[1:0])
      XS_MLO:  x_op = m_q & LO_MASK;
      XS_AB:   x_op = ab_cat;
      default: x_op = '0;
    endcase
    case (ctrl_q.opmode[3:2])
      YS_MHI:  y_op = m_q & ~LO_MASK;
      YS_C:    y_op = c_in;
      default: y_op = '0;
    endcase
    case (ctrl_q.opmode[6:4])
      ZS_P:    z_op = p_q;
      ZS_C:    z_op = c_in;
      default: z_op = '0;
    endcase

    addend = x_op + y_op + {{(P_W-1){1'b0}}, ctrl_q.carry};
    p_calc = (ctrl_q.alumode == ALU_SUB) ? (z_op - addend) : (z_op + addend);

    if (rst_p)     p_nx = '0;
    else if (ce_p) p_nx = p_calc;
    else           p_nx = p_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      p_q    <= '0;
    end else begin
      ctrl_q <= ctrl_nx;
      p_q    <= p_nx;
    end
  end
endmodule

// File: rtl/premac_slice.sv
`timescale 1ns/1ps
module premac_slice
  import premac_pkg::*;
#(
  parameter int A_W = 30,
  parameter int B_W = 18,
  parameter int D_W = 25,
  parameter int P_W = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic [D_W-1:0] d_in,
  input  logic [P_W-1:0] c_in,
  input  logic [6:0]     opmode_in,
  input  logic [3:0]     alumode_in,
  input  logic [4:0]     inmode_in,
  input  logic           carry_in,
  input  logic           ce_a,
  input  logic           ce_b1,
  input  logic           ce_b2,
  input  logic           ce_d,
  input  logic           ce_ad,
  input  logic           ce_m,
  input  logic           ce_p,
  input  logic           ce_ctrl,
  input  logic           ce_inmode,
  input  logic           rst_a,
  input  logic           rst_b,
  input  logic           rst_d,
  input  logic           rst_ad,
  input  logic           rst_m,
  input  logic           rst_p,
  input  logic           rst_ctrl,
  input  logic           rst_inmode,
  output logic [P_W-1:0] p_out
);
  localparam int PRE_W = D_W + 1;

  inm_t                    inm_q, inm_nx, inm_in;
  logic [A_W-1:0]          a_q;
  logic signed [PRE_W-1:0] ad_q;
  logic [B_W-1:0]          b1_q;
  logic [P_W-1:0]          m_q;

  always_comb begin
    inm_in = '{bsel_first: inmode_in[INM_BSEL_BIT], pre_sub: inmode_in[INM_SUB_BIT]};
    inm_nx = rst_inmode ? '0 : (ce_inmode ? inm_in : inm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inm_q <= '0;
    else        inm_q <= inm_nx;
  end

  premac_preadd #(.A_W(A_W), .D_W(D_W), .PRE_W(PRE_W)) preadd_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .d_in(d_in),
    .ce_a(ce_a), .ce_d(ce_d), .ce_ad(ce_ad),
    .rst_a(rst_a), .rst_d(rst_d), .rst_ad(rst_ad),
    .pre_sub(inm_q.pre_sub), .a_q(a_q), .ad_q(ad_q)
  );

  premac_mult #(.B_W(B_W), .PRE_W(PRE_W), .P_W(P_W)) mult_i (
    .clk(clk), .rst_n(rst_n), .b_in(b_in),
    .ce_b1(ce_b1), .ce_b2(ce_b2), .rst_b(rst_b),
    .ce_m(ce_m), .rst_m(rst_m), .bsel_first(inm_q.bsel_first),
    .ad_q(ad_q), .b1_q(b1_q), .m_q(m_q)
  );

  premac_postadd #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) post_i (
    .clk(clk), .rst_n(rst_n), .opmode_in(opmode_in), .alumode_in(alumode_in),
    .carry_in(carry_in), .ce_ctrl(ce_ctrl), .rst_ctrl(rst_ctrl),
    .m_q(m_q), .a_q(a_q), .b_q(b1_q), .c_in(c_in),
    .ce_p(ce_p), .rst_p(rst_p), .p_q(p_out)
  );
endmodule

// File: rtl/premac_slice_chk.sv
`timescale 1ns/1ps
module premac_slice_chk #(
  parameter int P_W = 48
) (
  input logic           clk,
  input logic           rst_n,
  input logic [6:0]     opmode_in,
  input logic [3:0]     alumode_in,
  input logic           carry_in,
  input logic           ce_ctrl,
  input logic           rst_ctrl,
  input logic           ce_p,
  input logic           rst_p,
  input logic [P_W-1:0] c_in,
  input logic [P_W-1:0] p_out
);
  // R1
  async_clear_chk: assert property (@(posedge clk) !rst_n |-> p_out == '0);

  // R4
  all_zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_ctrl && !rst_ctrl && opmode_in == 7'b0000000 && !carry_in) ##1 (ce_p && !rst_p)
    |=> p_out == '0);

  // R6
  accum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_ctrl && !rst_ctrl && opmode_in == 7'b0100000 && !carry_in && alumode_in == 4'b0000)
    ##1 (ce_p && !rst_p) |=> $stable(p_out));

  // R7
  c_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_ctrl && !rst_ctrl && opmode_in == 7'b0110000 && !carry_in && alumode_in == 4'b0000)
    ##1 (ce_p && !rst_p) |=> p_out == $past(c_in));

  // R10
  p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_p && !rst_p) |=> $stable(p_out));

  // R11
  p_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_p |=> p_out == '0);
endmodule

bind premac_slice premac_slice_chk #(.P_W(P_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .opmode_in(opmode_in), .alumode_in(alumode_in),
  .carry_in(carry_in), .ce_ctrl(ce_ctrl), .rst_ctrl(rst_ctrl),
  .ce_p(ce_p), .rst_p(rst_p), .c_in(c_in), .p_out(p_out)
);

// File: tb/premac_slice_tb_top.sv
`timescale 1ns/1ps
module premac_slice_tb_top;
  localparam int NH  = 2048;
  localparam int OFF = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [29:0] a_in;
  logic [17:0] b_in;
  logic [24:0] d_in;
  logic [47:0] c_in;
  logic [6:0]  opmode_in;
  logic [3:0]  alumode_in;
  logic [4:0]  inmode_in;
  logic        carry_in;
  logic ce_a, ce_b1, ce_b2, ce_d, ce_ad, ce_m, ce_p, ce_ctrl, ce_inmode;
  logic rst_a, rst_b, rst_d, rst_ad, rst_m, rst_p, rst_ctrl, rst_inmode;
  logic [47:0] p_out;

  int n_chk  = 0;
  int n_fail = 0;
  int t      = 0;
  bit done   = 0;

  // input history and reference stage values, indexed by edge number + OFF
  logic [29:0] h_a   [NH];
  logic [17:0] h_b   [NH];
  logic [24:0] h_d   [NH];
  logic [47:0] h_c   [NH];
  logic [6:0]  h_op  [NH];
  logic [3:0]  h_alu [NH];
  logic [4:0]  h_inm [NH];
  logic        h_ci  [NH];
  longint      r_ad  [NH];
  logic [47:0] r_m   [NH];
  logic [47:0] r_p   [NH];

  always #5 clk = ~clk;

  premac_slice dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .d_in(d_in), .c_in(c_in),
    .opmode_in(opmode_in), .alumode_in(alumode_in), .inmode_in(inmode_in),
    .carry_in(carry_in), .ce_a(ce_a), .ce_b1(ce_b1), .ce_b2(ce_b2), .ce_d(ce_d),
    .ce_ad(ce_ad), .ce_m(ce_m), .ce_p(ce_p), .ce_ctrl(ce_ctrl), .ce_inmode(ce_inmode),
    .rst_a(rst_a), .rst_b(rst_b), .rst_d(rst_d), .rst_ad(rst_ad), .rst_m(rst_m),
    .rst_p(rst_p), .rst_ctrl(rst_ctrl), .rst_inmode(rst_inmode), .p_out(p_out)
  );

  task automatic check(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: p_out=%h expected=%h (edge %0d)", req, act, exp, t);
    end
  endtask

  function automatic logic [47:0] post_ref(logic [6:0] op, logic [3:0] alu, logic ci,
      logic [47:0] m, logic [29:0] a, logic [17:0] b, logic [47:0] c, logic [47:0] pp);
    logic [47:0] x, y, z, s;
    x = (op[1:0] == 2'b01) ? (m & 48'h000000FFFFFF) : (op[1:0] == 2'b11) ? {a, b} : 48'd0;
    y = (op[3:2] == 2'b01) ? (m & 48'hFFFFFF000000) : (op[3:2] == 2'b11) ? c : 48'd0;
    z = (op[6:4] == 3'b010) ? pp : (op[6:4] == 3'b011) ? c : 48'd0;
    s = x + y + {47'd0, ci};
    return (alu == 4'b0011) ? (z - s) : (z + s);
  endfunction

  function automatic longint sa(logic [29:0] a);
    return longint'($signed(a[24:0]));
  endfunction

  // record current inputs, advance one edge, compare against the history model
  task automatic step(input string req);
    int     i;
    longint bs;
    i = t + OFF;
    h_a[i] = a_in; h_b[i] = b_in; h_d[i] = d_in; h_c[i] = c_in;
    h_op[i] = opmode_in; h_alu[i] = alumode_in; h_inm[i] = inmode_in; h_ci[i] = carry_in;
    r_ad[i] = h_inm[i-1][3] ? longint'($signed(h_d[i-1])) - sa(h_a[i-1])
                            : longint'($signed(h_d[i-1])) + sa(h_a[i-1]);
    bs      = h_inm[i-1][4] ? longint'($signed(h_b[i-1])) : longint'($signed(h_b[i-2]));
    r_m[i]  = 48'(r_ad[i-1] * bs);
    r_p[i]  = post_ref(h_op[i-1], h_alu[i-1], h_ci[i-1], r_m[i-1], h_a[i-1], h_b[i-1],
                       h_c[i], r_p[i-1]);
    @(posedge clk);
    @(negedge clk);
    check(p_out == r_p[i], req, p_out, r_p[i]);
    t++;
  endtask

  task automatic rand_ops();
    a_in = 30'($urandom);
    b_in = 18'($urandom);
    d_in = 25'($urandom);
    c_in = {16'($urandom), 32'($urandom)};
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [47:0] e0, e1, edb;
    logic [6:0] ops [8];
    ops = '{7'b0000101, 7'b0000000, 7'b0100101, 7'b0110000,
            7'b0001100, 7'b0000011, 7'b0001111, 7'b0111111};
    for (int k = 0; k < NH; k++) begin
      h_a[k] = '0; h_b[k] = '0; h_d[k] = '0; h_c[k] = '0; h_op[k] = '0;
      h_alu[k] = '0; h_inm[k] = '0; h_ci[k] = 1'b0; r_ad[k] = 0; r_m[k] = '0; r_p[k] = '0;
    end
    rst_n = 1'b0;
    a_in = 30'h3ABCDEF; b_in = 18'h1F00F; d_in = 25'h1234567; c_in = 48'hDEAD_BEEF_0001;
    opmode_in = 7'b0110000; alumode_in = '0; inmode_in = 5'b01000; carry_in = 1'b1;
    {ce_a, ce_b1, ce_b2, ce_d, ce_ad, ce_m, ce_p, ce_ctrl, ce_inmode} = '1;
    {rst_a, rst_b, rst_d, rst_ad, rst_m, rst_p, rst_ctrl, rst_inmode} = '0;
    wait_neg(3);
    // R1: reset state with busy inputs
    check(p_out == 48'd0, "R1", p_out, 48'd0);
    a_in = '0; b_in = '0; d_in = '0; c_in = '0; opmode_in = '0; carry_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2: (D - A) * B with four-clock latency
    opmode_in = 7'b0000101; alumode_in = 4'b0000; inmode_in = 5'b01000; carry_in = 1'b0;
    for (int k = 0; k < 300; k++) begin rand_ops(); step("R2"); end
    // R3 / R12: pre-adder sign and B register choice, low input-mode bits random
    for (int k = 0; k < 200; k++) begin
      rand_ops(); inmode_in = 5'($urandom); step("R3_R12");
    end
    inmode_in = 5'b01000;
    // R4: all selects zero
    opmode_in = 7'b0000000;
    for (int k = 0; k < 40; k++) begin rand_ops(); step("R4"); end
    check(p_out == 48'd0, "R4", p_out, 48'd0);
    // R5: product halves through X and Y
    for (int k = 0; k < 150; k++) begin
      rand_ops();
      case ($urandom % 3)
        0: opmode_in = 7'b0000001;
        1: opmode_in = 7'b0000100;
        default: opmode_in = 7'b0000101;
      endcase
      step("R5");
    end
    // R6: accumulate onto P
    opmode_in = 7'b0100101;
    for (int k = 0; k < 100; k++) begin rand_ops(); step("R6"); end
    // R7: C and A:B operand routes
    for (int k = 0; k < 150; k++) begin
      rand_ops(); opmode_in = ops[3 + ($urandom % 5)]; step("R7");
    end
    // R8 / R9: subtract, other ALU values, carry, per-cycle control changes
    for (int k = 0; k < 200; k++) begin
      rand_ops();
      opmode_in = ops[$urandom % 8];
      case ($urandom % 3)
        0: alumode_in = 4'b0000;
        1: alumode_in = 4'b0011;
        default: alumode_in = 4'($urandom);
      endcase
      carry_in  = 1'($urandom);
      inmode_in = 5'($urandom);
      step("R8_R9");
    end

    // directed phase: constant operands
    opmode_in = 7'b0000101; alumode_in = 4'b0000; inmode_in = 5'b01000; carry_in = 1'b0;
    a_in = 30'h0000_0123; b_in = 18'h3FFF9; d_in = 25'h1FFFF00;
    e0  = 48'((longint'($signed(d_in)) - sa(a_in)) * longint'($signed(b_in)));
    edb = 48'(longint'($signed(d_in)) * longint'($signed(b_in)));
    wait_neg(6);
    check(p_out == e0, "R2", p_out, e0);
    // R10: A enable low keeps the old A
    ce_a = 1'b0; a_in = 30'h1000_0F0F;
    e1 = 48'((longint'($signed(d_in)) - sa(a_in)) * longint'($signed(b_in)));
    wait_neg(6);
    check(p_out == e0, "R10", p_out, e0);
    ce_a = 1'b1;
    wait_neg(6);
    check(p_out == e1, "R10", p_out, e1);
    // R11: one-cycle clear of A shows once at P three edges later
    rst_a = 1'b1;
    @(negedge clk);
    rst_a = 1'b0;
    wait_neg(3);
    check(p_out == edb, "R11", p_out, edb);
    @(negedge clk);
    check(p_out == e1, "R11", p_out, e1);
    // R10: P enable low freezes the output
    ce_p = 1'b0; a_in = 30'h0000_0123;
    wait_neg(6);
    check(p_out == e1, "R10", p_out, e1);
    // R11: clear wins over a low enable
    rst_p = 1'b1;
    @(negedge clk);
    check(p_out == 48'd0, "R11", p_out, 48'd0);
    rst_p = 1'b0; ce_p = 1'b1;
    wait_neg(2);
    check(p_out == e0, "R11", p_out, e0);
    // R1: asynchronous clear mid-cycle
    #2 rst_n = 1'b0;
    #1 check(p_out == 48'd0, "R1", p_out, 48'd0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule